// File: doc/BRIEF.md
# Interrupt-on-Terminal-Count Down Counter

This block is a single timer channel that raises its output once a host-loaded count has been consumed by pulses on a separate timer clock. The host first issues a control-word strobe, which arms the channel, drives the output low and selects whether a count is written as a single low byte or as a low byte followed by a high byte. The written count waits in a count register. The next full pulse of the timer clock copies it into the counting element without decrementing it, and each later pulse with the gate high takes one off. The output rises when the counting element steps from one to zero. After that the element keeps wrapping downward and the output stays high until the host writes again.

All logic runs on the system clock `clk_i`. The timer clock `tclk_i` and the gate `gate_i` are level inputs that the system clock samples, so they must already be synchronous to it. A timer-clock pulse is a low-to-high transition followed later by a high-to-low transition. The gate is sampled at the rising transition, and the count changes right after the falling one. A status output shows that a count has been written but not yet moved into the counting element. The live counting-element value is brought out so the host can observe it.

Top module: `tc_intr_counter`

## Requirements
- R1: A control-word strobe (`cw_wr_i`) drives `out_o` low in the next cycle, resets the byte order to low byte first, cancels any pending load and stops decrementing until a new count has been loaded.
- R2: With `two_byte_i` = 0, one data write forms the whole count: the high byte is 0x00 and the written byte is the low byte.
- R3: The timer-clock pulse that follows a completed count write copies the count into `count_o` unchanged. For a count N (1..65535) with the gate high, `out_o` rises on pulse N+1 after the write.
- R4: A pulse whose rising transition sees `gate_i` low leaves `count_o` unchanged, except that a pending load still happens. `out_o` is never altered by the gate. A count loaded while the gate is low raises `out_o` N gated pulses after the gate goes high.
- R5: `out_o` rises exactly when `count_o` steps from 0x0001 to 0x0000. It then stays high, while later pulses keep decrementing with wrap from 0x0000 to 0xFFFF, until the next control word or data write.
- R6: A data write while counting drives `out_o` low at once. The new count is loaded on the next pulse, and counting continues from it.
- R7: With `two_byte_i` = 1, the first data write is the low byte. It drives `out_o` low and freezes `count_o`. The second write is the high byte, and it lets the combined count load on the next pulse.
- R8: A loaded count of 0x0000 steps to 0xFFFF on the next gated pulse, with `out_o` still low, and raises `out_o` on gated pulse 65536 after the load.
- R9: A pulse counts only once both transitions have been seen. A high level on `tclk_i` alone changes nothing. The count change appears in the cycle after the falling transition is sampled.
- R10: `null_o` is set by a control-word strobe or a completed count write and is cleared by the pulse that loads the count.
- R11: After reset, `out_o` = 0, `count_o` = 0x0000 and `null_o` = 0, and no pulse decrements until a count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tclk_i | input | 1 | Timer clock level, synchronous to clk_i |
| gate_i | input | 1 | Count enable level, sampled at the timer clock rise |
| cw_wr_i | input | 1 | Control-word write strobe |
| two_byte_i | input | 1 | Access mode: 0 low byte only, 1 low then high byte |
| data_wr_i | input | 1 | Count byte write strobe |
| data_i | input | 8 | Count byte |
| out_o | output | 1 | Terminal-count output |
| null_o | output | 1 | Count written but not yet loaded |
| count_o | output | 16 | Current counting-element value |

## Verification
A corrupted byte pointer or a stuck freeze flag changes the loaded value or the run of `count_o` on the first pulse after the write, so the per-clock comparison catches it within two system cycles. An off-by-one in load versus decrement shows as `out_o` rising one pulse early or late. A wrong wrap or 65536 interpretation only shows at the end of the long zero-count run, so that run is carried out to its final pulse. A gate that is sampled at the wrong moment shows at once in the gated-hold sequences.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    ACC_LO_ONLY = 1'b0,
    ACC_LO_HI   = 1'b1
  } acc_e;

  typedef enum logic {
    PTR_LO = 1'b0,
    PTR_HI = 1'b1
  } ptr_e;
endpackage

// File: rtl/tc_pulse_det.sv
module tc_pulse_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_i,
  input  logic gate_i,
  output logic pulse_o,
  output logic gate_s_o
);
  logic tclk_q, armed_q, gate_q;
  logic rise, fall;

  assign rise = tclk_i & ~tclk_q;
  assign fall = ~tclk_i & tclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tclk_q  <= 1'b0;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      tclk_q <= tclk_i;
      if (rise) begin
        armed_q <= 1'b1;
        gate_q  <= gate_i;
      end else if (fall) begin
        armed_q <= 1'b0;
      end
    end
  end

  // pulse completes on the falling transition after a seen rise
  assign pulse_o  = fall & armed_q;
  assign gate_s_o = gate_q;

  p_no_back_to_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tc_count_reg.sv
module tc_count_reg
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_wr_i,
  input  logic              two_byte_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              pulse_i,
  output logic [CNT_W-1:0]  cr_o,
  output logic              load_req_o,
  output logic              hold_o,
  output logic              null_o
);
  acc_e              acc;
  ptr_e              ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  cr_q;
  logic              req_q, hold_q, null_q;

  assign acc = acc_e'(two_byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= PTR_LO;
      lo_q   <= '0;
      cr_q   <= '0;
      req_q  <= 1'b0;
      hold_q <= 1'b0;
      null_q <= 1'b0;
    end else if (cw_wr_i) begin
      ptr_q  <= PTR_LO;
      req_q  <= 1'b0;
      hold_q <= 1'b0;
      null_q <= 1'b1;
    end else if (wr_i) begin
      if (acc == ACC_LO_ONLY) begin
        cr_q   <= {{BYTE_W{1'b0}}, data_i};
        req_q  <= 1'b1;
        null_q <= 1'b1;
      end else if (ptr_q == PTR_LO) begin
        lo_q   <= data_i;
        ptr_q  <= PTR_HI;
        hold_q <= 1'b1;
      end else begin
        cr_q   <= {data_i, lo_q};
        ptr_q  <= PTR_LO;
        hold_q <= 1'b0;
        req_q  <= 1'b1;
        null_q <= 1'b1;
      end
    end else if (pulse_i && req_q) begin
      req_q  <= 1'b0;
      null_q <= 1'b0;
    end
  end

  assign cr_o       = cr_q;
  assign load_req_o = req_q;
  assign hold_o     = hold_q;
  assign null_o     = null_q;

  p_null_clear_on_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && req_q && !wr_i && !cw_wr_i) |=> !null_o);
  p_cw_cancels_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr_i |=> (!load_req_o && !hold_o));
endmodule

// File: rtl/tc_count_elem.sv
module tc_count_elem #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             gate_s_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cr_i,
  input  logic             hold_i,
  input  logic             stop_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ce_q;
  logic             run_q, out_q, dec;

  assign dec = pulse_i & run_q & ~hold_i & gate_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else if (stop_i || clr_i) begin
      out_q <= 1'b0;
      if (stop_i) run_q <= 1'b0;
    end else if (load_i) begin
      ce_q  <= cr_i;
      run_q <= 1'b1;
    end else if (dec) begin
      ce_q <= ce_q - ONE;
      if (ce_q == ONE) out_q <= 1'b1;
    end
  end

  assign count_o = ce_q;
  assign out_o   = out_q;

  p_load_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && !stop_i) |=> (count_o == $past(cr_i)));
  p_gate_low_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !gate_s_i && !load_i) |=> $stable(count_o));
  p_out_rise_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> (count_o == '0));
  p_out_sticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o && !clr_i && !stop_i) |=> out_o);
  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/tc_intr_counter.sv
module tc_intr_counter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              gate_i,
  input  logic              cw_wr_i,
  input  logic              two_byte_i,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              out_o,
  output logic              null_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             pulse, gate_s, load_req, hold;
  logic [CNT_W-1:0] cr;

  tc_pulse_det u_pdet (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tclk_i  (tclk_i),
    .gate_i  (gate_i),
    .pulse_o (pulse),
    .gate_s_o(gate_s)
  );

  tc_count_reg #(.BYTE_W(BYTE_W)) u_creg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cw_wr_i   (cw_wr_i),
    .two_byte_i(two_byte_i),
    .wr_i      (data_wr_i),
    .data_i    (data_i),
    .pulse_i   (pulse),
    .cr_o      (cr),
    .load_req_o(load_req),
    .hold_o    (hold),
    .null_o    (null_o)
  );

  tc_count_elem #(.CNT_W(CNT_W)) u_elem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse),
    .gate_s_i(gate_s),
    .load_i  (pulse & load_req),
    .cr_i    (cr),
    .hold_i  (hold),
    .stop_i  (cw_wr_i),
    .clr_i   (data_wr_i),
    .count_o (count_o),
    .out_o   (out_o)
  );

  p_cw_out_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr_i |=> !out_o);
  p_write_out_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> !out_o);
endmodule

// File: tb/sim_tc_intr_counter.sv
`timescale 1ns/1ps
module sim_tc_intr_counter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tclk = 1'b0, gate = 1'b0, cw = 1'b0, two = 1'b0, dwr = 1'b0;
  logic [7:0]  din = '0;
  logic        out_w, null_w;
  logic [15:0] cnt_w;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tc_intr_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .gate_i(gate),
    .cw_wr_i(cw), .two_byte_i(two), .data_wr_i(dwr), .data_i(din),
    .out_o(out_w), .null_o(null_w), .count_o(cnt_w)
  );

  // behavioural reference
  int m_cnt, m_cr, m_lo;
  bit m_out, m_null, m_run, m_hold, m_pend, m_ptr, m_armed, m_gs, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cr = 0; m_lo = 0; m_out = 0; m_null = 0; m_run = 0;
      m_hold = 0; m_pend = 0; m_ptr = 0; m_armed = 0; m_gs = 0; m_prev = 0;
    end else begin
      bit rise, fall, pls, o_pend, o_hold, o_gs;
      int o_cr;
      rise = tclk && !m_prev;
      fall = !tclk && m_prev;
      pls = fall && m_armed;
      o_pend = m_pend; o_hold = m_hold; o_gs = m_gs; o_cr = m_cr;
      m_prev = tclk;
      if (rise) begin m_armed = 1; m_gs = gate; end
      else if (fall) m_armed = 0;
      if (cw) begin
        m_ptr = 0; m_hold = 0; m_pend = 0; m_null = 1;
      end else if (dwr) begin
        if (!two) begin m_cr = din; m_pend = 1; m_null = 1; end
        else if (!m_ptr) begin m_lo = din; m_ptr = 1; m_hold = 1; end
        else begin m_cr = din * 256 + m_lo; m_ptr = 0; m_hold = 0; m_pend = 1; m_null = 1; end
      end else if (pls && o_pend) begin
        m_pend = 0; m_null = 0;
      end
      if (cw || dwr) begin
        m_out = 0;
        if (cw) m_run = 0;
      end else if (pls && o_pend) begin
        m_cnt = o_cr; m_run = 1;
      end else if (pls && m_run && !o_hold && o_gs) begin
        if (m_cnt == 1) m_out = 1;
        m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (out_w !== m_out || null_w !== m_null || cnt_w !== 16'(m_cnt)) begin
        n_fail++;
        $display("FAIL model R3/R5/R10 t=%0t: out=%0b null=%0b cnt=%h expected out=%0b null=%0b cnt=%h",
                 $time, out_w, null_w, cnt_w, m_out, m_null, 16'(m_cnt));
      end
    end
  end

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(logic g);
    @(negedge clk); gate = g; tclk = 1'b1;
    @(negedge clk); tclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); dwr = 1'b1; din = d;
    @(negedge clk); dwr = 1'b0;
  endtask

  task automatic ctl(logic t);
    @(negedge clk); cw = 1'b1; two = t;
    @(negedge clk); cw = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 out", {16'd0, out_w}, 17'd0);
    chk("R11 count", {1'b0, cnt_w}, 17'd0);
    chk("R11 null", {16'd0, null_w}, 17'd0);
    tick(1'b1);
    chk("R11 no count before load", {1'b0, cnt_w}, 17'd0);

    // one-byte mode
    ctl(1'b0);
    chk("R1 out low after cw", {16'd0, out_w}, 17'd0);
    chk("R10 null set by cw", {16'd0, null_w}, 17'd1);
    wr(8'h04);
    chk("R10 null after write", {16'd0, null_w}, 17'd1);
    tick(1'b1);
    chk("R3 load without decrement", {1'b0, cnt_w}, 17'h4);
    chk("R10 null cleared on load", {16'd0, null_w}, 17'd0);
    for (int i = 0; i < 3; i++) tick(1'b1);
    chk("R3 out low before N+1", {out_w, cnt_w}, {1'b0, 16'h1});
    tick(1'b1);
    chk("R3 R5 out high at N+1", {out_w, cnt_w}, {1'b1, 16'h0});
    tick(1'b1);
    chk("R5 wrap keeps out high", {out_w, cnt_w}, {1'b1, 16'hFFFF});
    wr(8'h05);
    chk("R6 write drops out", {16'd0, out_w}, 17'd0);
    tick(1'b1);
    chk("R2 R6 one-byte reload", {1'b0, cnt_w}, 17'h0005);
    tick(1'b1); tick(1'b1);
    // R9 half pulse
    @(negedge clk); gate = 1'b1; tclk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 rise alone no change", {1'b0, cnt_w}, 17'h3);
    tclk = 1'b0;
    @(negedge clk);
    chk("R9 change after fall", {1'b0, cnt_w}, 17'h2);

    // gate
    wr(8'h03);
    tick(1'b0);
    chk("R4 load with gate low", {1'b0, cnt_w}, 17'h3);
    tick(1'b0); tick(1'b0);
    chk("R4 gate low holds", {out_w, cnt_w}, {1'b0, 16'h3});
    tick(1'b1); tick(1'b1);
    chk("R4 out low before N", {out_w, cnt_w}, {1'b0, 16'h1});
    tick(1'b1);
    chk("R4 out high N gated pulses", {out_w, cnt_w}, {1'b1, 16'h0});
    tick(1'b0);
    chk("R4 gate no effect on out", {out_w, cnt_w}, {1'b1, 16'h0});

    // two-byte mode
    ctl(1'b1);
    keep = cnt_w;
    tick(1'b1);
    chk("R1 stopped after cw", {out_w, cnt_w}, {1'b0, keep});
    wr(8'h02); wr(8'h01);
    tick(1'b1);
    chk("R7 two-byte load", {1'b0, cnt_w}, 17'h0102);
    tick(1'b1);
    chk("R7 counting", {1'b0, cnt_w}, 17'h0101);
    wr(8'h10);
    tick(1'b1); tick(1'b1);
    chk("R7 first byte freezes", {out_w, cnt_w}, {1'b0, 16'h0101});
    wr(8'h00);
    tick(1'b1);
    chk("R7 second byte loads", {1'b0, cnt_w}, 17'h0010);

    // zero count = 65536
    wr(8'h00); wr(8'h00);
    tick(1'b1);
    chk("R8 zero loaded", {out_w, cnt_w}, {1'b0, 16'h0});
    tick(1'b1);
    chk("R8 wrap low out", {out_w, cnt_w}, {1'b0, 16'hFFFF});
    for (int i = 0; i < 65534; i++) tick(1'b1);
    chk("R8 one before end", {out_w, cnt_w}, {1'b0, 16'h1});
    tick(1'b1);
    chk("R8 out high at 65536", {out_w, cnt_w}, {1'b1, 16'h0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule